// File: doc/BRIEF.md
# Status Register and Write Guard for a Serial Nonvolatile Memory

This block sits between the command decoder of a serial-bus nonvolatile memory and its array write engine. It owns the write-enable latch and the three nonvolatile protection bits: a hardware-lock enable and a two-bit protection level. From them it builds the status byte that the bus logic shifts out on a status read. It answers, for every queried address, whether a byte write there may go ahead. It also decides whether a status-register write may be accepted, using the write-protect input, the lock enable and the latch.

The command decoder reports decoded events as one-cycle strobes. These are latch set and latch clear, and a status byte received in a status write. The block watches the select line, the write-protect line and the engine's busy flag for edges. A status write is held pending until select is released. It is then launched with a one-cycle start pulse, and its new bits take effect when busy falls. A write-protect falling edge can still cancel the write while it is pending. The protection bits hold their contents across the interface reset and start from parameter values.

Top module: `status_guard`

## Requirements
- R1: When busy is low, stat_byte is {lock, 3'b000, level[1], level[0], wel, 1'b0}: bit 7 is the lock enable, bits 3:2 are the protection level, bit 1 is the write-enable latch, and bit 0 is the busy indication, 0 meaning idle.
- R2: While busy is high, stat_byte reads 8'hFF.
- R3: A cmd_wel_set strobe sets the latch and a cmd_wel_clr strobe clears it, whatever the level of wp_n. Clear wins if both arrive together. The latch clears on every falling edge of busy and is clear after rst.
- R4: With the latch set and busy low, q_ok[i] is high unless the top two address bits fall in the protected area. Level 00 protects nothing. Level 01 protects top bits 11, the top quarter. Level 10 protects top bit 1, the top half. Level 11 protects every address.
- R5: With the latch clear, every q_ok bit and sr_wr_ok are low.
- R6: sr_wr_ok is high only when the latch is set, busy is low, no status write is in flight, and the hardware lock is inactive. The lock is active exactly when lock enable is 1 and wp_n is low. An sr_load strobe while sr_wr_ok is low changes nothing.
- R7: An accepted sr_load holds sr_data as pending. On the next rising edge of cs_n, sr_start pulses high for exactly one cycle, in the cycle after that edge. The new lock enable (sr_data bit 7) and level (sr_data bits 3:2) appear in stat_byte once busy falls.
- R8: A falling edge of wp_n while a status write is pending and lock enable is 1 cancels it, and no sr_start follows. A falling edge after sr_start has no effect on the update.
- R9: lock enable and level come from parameters at start-up and are not altered by rst.
- R10: While busy is high, sr_load, cmd_wel_set and cmd_wel_clr are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high interface reset |
| cs_n | input | 1 | Bus select, low while a transaction is open |
| wp_n | input | 1 | Write-protect input, active low |
| busy | input | 1 | High while the internal write cycle runs |
| cmd_wel_set | input | 1 | Strobe: set write-enable latch |
| cmd_wel_clr | input | 1 | Strobe: clear write-enable latch |
| sr_load | input | 1 | Strobe: status write byte received |
| sr_data | input | 8 | Status write byte |
| q_addr | input | NQ*AW | Packed query addresses, port i in bits [i*AW +: AW] |
| q_ok | output | NQ | Per query port: array write allowed at that address |
| sr_wr_ok | output | 1 | Status write currently allowed |
| sr_start | output | 1 | One-cycle pulse launching a status write cycle |
| stat_byte | output | 8 | Status byte for the read path |

## Verification
The latch is walked through set, clear, set and clear together, busy-end clearing and strobes during busy. These separate command handling from cycle-end handling. All four protection levels are visited, and each is queried just below and at its protected boundary, which shows whether the decode looks at the right address bits. Status writes are run with write-protect held high and low, and with lock enable on and off. One write-protect fall lands while a write is pending and another after launch, so a cancel that comes too late or too early shows up. Between runs an interface reset checks that the protection bits survive while the latch does not.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;

    localparam int STAT_W = 8;

    // Nonvolatile protection state.
    typedef struct packed {
        logic       lock;   // honour wp_n when set
        logic [1:0] level;  // top-down protected fraction
    } nv_bits_t;

    // Encodings of the protection level field.
    typedef enum logic [1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_ALL     = 2'b11
    } prot_level_e;

    // Bit positions in the status byte that the read path decodes.
    localparam int SB_LOCK = 7;
    localparam int SB_LVH  = 3;
    localparam int SB_LVL  = 2;
    localparam int SB_WEL  = 1;
    localparam int SB_BSY  = 0;

    // Protection decision from the level and the two top address bits.
    function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top2);
        logic hit;
        case (prot_level_e'(lvl))
            LVL_NONE:    hit = 1'b0;
            LVL_QUARTER: hit = (top2 == 2'b11);
            LVL_HALF:    hit = top2[1];
            default:     hit = 1'b1;
        endcase
        return hit;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input nv_bits_t nv,
                                                      input logic wel,
                                                      input logic bsy);
        logic [STAT_W-1:0] s;
        if (bsy) begin
            s = '1;
        end else begin
            s = '0;
            s[SB_LOCK] = nv.lock;
            s[SB_LVH]  = nv.level[1];
            s[SB_LVL]  = nv.level[0];
            s[SB_WEL]  = wel;
        end
        return s;
    endfunction

    function automatic nv_bits_t unpack_nv(input logic [STAT_W-1:0] b);
        nv_bits_t n;
        n.lock  = b[SB_LOCK];
        n.level = {b[SB_LVH], b[SB_LVL]};
        return n;
    endfunction

endpackage

// File: rtl/sg_edges.sv
module sg_edges #(
    parameter int           N    = 3,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= IDLE[i];
            else     prev_q[i] <= sig[i];
        end
        assign rise[i] = ~prev_q[i] &  sig[i];
        assign fall[i] =  prev_q[i] & ~sig[i];
    end
endmodule

// File: rtl/sg_wel.sv
module sg_wel (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic cyc_done,
    input  logic set_req,
    input  logic clr_req,
    output logic wel
);
    logic wel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q <= 1'b0;
        end else if (!busy && clr_req) begin
            wel_q <= 1'b0;
        end else if (!busy && set_req) begin
            wel_q <= 1'b1;
        end else if (cyc_done) begin
            wel_q <= 1'b0;
        end
    end

    assign wel = wel_q;
endmodule

// File: rtl/sg_sr_ctrl.sv
module sg_sr_ctrl
    import status_guard_pkg::*;
#(
    parameter logic       INIT_LOCK  = 1'b0,
    parameter logic [1:0] INIT_LEVEL = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAT_W-1:0] data,
    input  logic              allow,
    input  logic              sel_open,
    input  logic              sel_close,
    input  logic              wp_drop,
    input  logic              cyc_done,
    output nv_bits_t          nv,
    output logic              inflight,
    output logic              start
);
    localparam nv_bits_t NV_INIT = '{lock: INIT_LOCK, level: INIT_LEVEL};

    nv_bits_t nv_q = NV_INIT;  // no interface reset: models nonvolatile cells
    nv_bits_t stage_q;
    logic     pend_q;
    logic     infl_q;
    logic     start_q;
    logic     commit;
    logic     cancel;
    logic     apply;

    assign cancel = pend_q && wp_drop && nv_q.lock;
    assign commit = pend_q && sel_close && !cancel;
    assign apply  = cyc_done && infl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            infl_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= commit;
            if (load && allow)            pend_q <= 1'b1;
            else if (cancel || commit)    pend_q <= 1'b0;
            else if (sel_open)            pend_q <= 1'b0;
            if (commit)                   infl_q <= 1'b1;
            else if (apply)               infl_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && load && allow) stage_q <= unpack_nv(data);
    end

    always_ff @(posedge clk) begin
        if (!rst && apply) nv_q <= stage_q;
    end

    assign nv       = nv_q;
    assign inflight = infl_q;
    assign start    = start_q;
endmodule

// File: rtl/sg_addr_guard.sv
module sg_addr_guard
    import status_guard_pkg::*;
#(
    parameter int AW = 15,
    parameter int NQ = 2
) (
    input  logic [NQ*AW-1:0] addr,
    input  logic [1:0]       level,
    input  logic             enable,
    output logic [NQ-1:0]    ok
);
    localparam int TOP = AW - 1;

    for (genvar i = 0; i < NQ; i++) begin : g_port
        logic [AW-1:0] a;
        assign a     = addr[i*AW +: AW];
        assign ok[i] = enable && !prot_hit(level, a[TOP -: 2]);
    end
endmodule

// File: rtl/status_guard.sv
module status_guard
    import status_guard_pkg::*;
#(
    parameter int         AW         = 15,
    parameter int         NQ         = 2,
    parameter logic       INIT_LOCK  = 1'b0,
    parameter logic [1:0] INIT_LEVEL = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              cmd_wel_set,
    input  logic              cmd_wel_clr,
    input  logic              sr_load,
    input  logic [7:0]        sr_data,
    input  logic [NQ*AW-1:0]  q_addr,
    output logic [NQ-1:0]     q_ok,
    output logic              sr_wr_ok,
    output logic              sr_start,
    output logic [7:0]        stat_byte
);
    localparam int E_CS = 0;
    localparam int E_WP = 1;
    localparam int E_BY = 2;
    localparam int NE   = 3;
    localparam logic [NE-1:0] E_IDLE = 3'b011;

    logic [NE-1:0] e_rise;
    logic [NE-1:0] e_fall;
    logic          cyc_done;
    logic          wel;
    logic          inflight;
    logic          hw_lock;
    nv_bits_t      nv;

    sg_edges #(.N(NE), .IDLE(E_IDLE)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .sig  ({busy, wp_n, cs_n}),
        .rise (e_rise),
        .fall (e_fall)
    );

    assign cyc_done = e_fall[E_BY];

    sg_wel u_wel (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .cyc_done (cyc_done),
        .set_req  (cmd_wel_set),
        .clr_req  (cmd_wel_clr),
        .wel      (wel)
    );

    assign hw_lock  = nv.lock && !wp_n;
    assign sr_wr_ok = wel && !busy && !inflight && !hw_lock;

    sg_sr_ctrl #(.INIT_LOCK(INIT_LOCK), .INIT_LEVEL(INIT_LEVEL)) u_sr (
        .clk       (clk),
        .rst       (rst),
        .load      (sr_load),
        .data      (sr_data),
        .allow     (sr_wr_ok),
        .sel_open  (e_fall[E_CS]),
        .sel_close (e_rise[E_CS]),
        .wp_drop   (e_fall[E_WP]),
        .cyc_done  (cyc_done),
        .nv        (nv),
        .inflight  (inflight),
        .start     (sr_start)
    );

    sg_addr_guard #(.AW(AW), .NQ(NQ)) u_guard (
        .addr   (q_addr),
        .level  (nv.level),
        .enable (wel && !busy),
        .ok     (q_ok)
    );

    assign stat_byte = pack_status(nv, wel, busy);
endmodule

// File: rtl/status_guard_chk.sv
module status_guard_chk #(
    parameter int AW = 15,
    parameter int NQ = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              wp_n,
    input logic              busy,
    input logic              cmd_wel_set,
    input logic              cmd_wel_clr,
    input logic              sr_load,
    input logic [7:0]        sr_data,
    input logic [NQ*AW-1:0]  q_addr,
    input logic [NQ-1:0]     q_ok,
    input logic              sr_wr_ok,
    input logic              sr_start,
    input logic [7:0]        stat_byte
);
    // R1: reserved bits and busy bit read zero while idle
    a_r1_idle_layout: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (stat_byte[6:4] == 3'b000 && !stat_byte[0]));

    // R2: busy forces all ones
    a_r2_busy_ones: assert property (@(posedge clk) disable iff (rst)
        busy |-> stat_byte == 8'hFF);

    // R3: clear strobe while idle leaves the latch clear next cycle
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (cmd_wel_clr && !busy) |=> (!stat_byte[1] || busy));

    // R5: latch clear blocks every write
    a_r5_no_wel_no_write: assert property (@(posedge clk) disable iff (rst)
        (!busy && !stat_byte[1]) |-> (q_ok == '0 && !sr_wr_ok));

    // R4: full protection level blocks all queried addresses
    a_r4_all_protected: assert property (@(posedge clk) disable iff (rst)
        (!busy && stat_byte[3:2] == 2'b11) |-> q_ok == '0);

    // R6: hardware lock blocks status writes
    a_r6_hw_lock: assert property (@(posedge clk) disable iff (rst)
        (!busy && stat_byte[7] && !wp_n) |-> !sr_wr_ok);

    // R7: launch pulse lasts one cycle and follows a released select
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (rst)
        sr_start |=> !sr_start);
    a_r7_start_after_release: assert property (@(posedge clk) disable iff (rst)
        sr_start |-> $past(cs_n));

    // R10: busy blocks status writes
    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sr_wr_ok);
endmodule

bind status_guard status_guard_chk #(.AW(AW), .NQ(NQ)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .wp_n        (wp_n),
    .busy        (busy),
    .cmd_wel_set (cmd_wel_set),
    .cmd_wel_clr (cmd_wel_clr),
    .sr_load     (sr_load),
    .sr_data     (sr_data),
    .q_addr      (q_addr),
    .q_ok        (q_ok),
    .sr_wr_ok    (sr_wr_ok),
    .sr_start    (sr_start),
    .stat_byte   (stat_byte)
);

// File: tb/status_guard_test.sv
module status_guard_test;
    localparam int AW = 15;
    localparam int NQ = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic wp_n = 1'b1;
    logic busy = 1'b0;
    logic cmd_wel_set = 1'b0;
    logic cmd_wel_clr = 1'b0;
    logic sr_load = 1'b0;
    logic [7:0] sr_data = 8'h00;
    logic [AW-1:0] qa0 = '0;
    logic [AW-1:0] qa1 = '0;
    logic [NQ-1:0] q_ok;
    logic sr_wr_ok;
    logic sr_start;
    logic [7:0] stat_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    status_guard #(.AW(AW), .NQ(NQ)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n), .busy(busy),
        .cmd_wel_set(cmd_wel_set), .cmd_wel_clr(cmd_wel_clr),
        .sr_load(sr_load), .sr_data(sr_data), .q_addr({qa1, qa0}),
        .q_ok(q_ok), .sr_wr_ok(sr_wr_ok), .sr_start(sr_start),
        .stat_byte(stat_byte)
    );

    // ---------------- reference model ----------------
    bit m_wel = 0, m_lock = 0, m_pend = 0, m_fly = 0, m_start = 0;
    bit [1:0] m_lvl = 2'b00;
    bit m_s_lock = 0;
    bit [1:0] m_s_lvl = 2'b00;
    bit p_busy = 0, p_cs = 1, p_wp = 1;

    function automatic bit m_guarded(input bit [AW-1:0] a);
        int frac_lo;
        frac_lo = (m_lvl == 2'b00) ? (1 << AW) :
                  (m_lvl == 2'b01) ? (3 << (AW - 2)) :
                  (m_lvl == 2'b10) ? (1 << (AW - 1)) : 0;
        return int'(a) >= frac_lo;
    endfunction

    function automatic bit m_srok();
        return m_wel && !busy && !m_fly && !(m_lock && !wp_n);
    endfunction

    function automatic bit [7:0] m_stat();
        if (busy) return 8'hFF;
        return {m_lock, 3'b000, m_lvl, m_wel, 1'b0};
    endfunction

    task automatic compare(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit ok_now, done, cfall, crise, wfall, cancel, commit;
        if (rst) begin
            m_wel = 0; m_pend = 0; m_fly = 0; m_start = 0;
            p_busy = 0; p_cs = 1; p_wp = 1;
        end else begin
            ok_now = m_srok();
            done   = p_busy && !busy;
            cfall  = p_cs && !cs_n;
            crise  = !p_cs && cs_n;
            wfall  = p_wp && !wp_n;
            cancel = m_pend && wfall && m_lock;
            commit = m_pend && crise && !cancel;
            m_start = commit;
            if (done && m_fly) begin
                m_lock = m_s_lock; m_lvl = m_s_lvl; m_fly = 0;
            end
            if (commit) m_fly = 1;
            if (sr_load && ok_now) begin
                m_pend = 1; m_s_lock = sr_data[7]; m_s_lvl = sr_data[3:2];
            end else if (cancel || commit || cfall) begin
                m_pend = 0;
            end
            if (!busy && cmd_wel_clr)      m_wel = 0;
            else if (!busy && cmd_wel_set) m_wel = 1;
            else if (done)                 m_wel = 0;
            p_busy = busy; p_cs = cs_n; p_wp = wp_n;
        end
        #1;
        if (!rst) begin
            compare("R1 R2 R3 R9 R10 stat_byte", stat_byte, m_stat());
            compare("R4 R5 q_ok[0]", q_ok[0], (m_wel && !busy && !m_guarded(qa0)));
            compare("R4 R5 q_ok[1]", q_ok[1], (m_wel && !busy && !m_guarded(qa1)));
            compare("R6 R8 sr_wr_ok", sr_wr_ok, m_srok());
            compare("R7 R8 sr_start", sr_start, m_start);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_set(); cmd_wel_set = 1; tick(); cmd_wel_set = 0; endtask
    task automatic strobe_clr(); cmd_wel_clr = 1; tick(); cmd_wel_clr = 0; endtask

    task automatic run_busy(input int n);
        busy = 1; tick(n); busy = 0; tick();
    endtask

    // opens select, loads byte, closes select; returns with start visible
    task automatic sr_write(input bit [7:0] b);
        cs_n = 0; tick();
        sr_data = b; sr_load = 1; tick(); sr_load = 0;
        cs_n = 1; tick();
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        tick(3);
        rst = 0; tick();
        compare("R1 R9 reset status", stat_byte, 8'h00);

        strobe_set();
        compare("R3 set latch", stat_byte, 8'h02);
        qa0 = 15'h7FFF; qa1 = 15'h0000; #0;
        compare("R4 level none top", q_ok, 2'b11);

        sr_write(8'h84);
        compare("R7 start pulse", sr_start, 1);
        tick();
        compare("R7 pulse ends", sr_start, 0);
        busy = 1; tick();
        compare("R2 busy ones", stat_byte, 8'hFF);
        tick(3); busy = 0; tick();
        compare("R7 new bits after busy", stat_byte, 8'h84);

        strobe_set();
        qa0 = 15'h6000; qa1 = 15'h5FFF; tick();
        compare("R4 quarter boundary", q_ok, 2'b10);

        wp_n = 0; tick();
        compare("R6 hw lock blocks", sr_wr_ok, 0);
        cs_n = 0; tick(); sr_data = 8'h00; sr_load = 1; tick(); sr_load = 0;
        cs_n = 1; tick();
        compare("R6 blocked load no start", sr_start, 0);
        strobe_clr();
        compare("R3 clear with wp low", stat_byte, 8'h84);
        tick(2);
        compare("R6 blocked load kept bits", stat_byte, 8'h84);

        wp_n = 1; strobe_set();
        compare("R6 lock off when wp high", sr_wr_ok, 1);
        cs_n = 0; tick(); sr_data = 8'h08; sr_load = 1; tick(); sr_load = 0;
        wp_n = 0; tick();
        cs_n = 1; tick();
        compare("R8 cancelled no start", sr_start, 0);
        compare("R8 bits unchanged", stat_byte, 8'h86);

        wp_n = 1; tick();
        sr_write(8'h0C);
        compare("R7 start second write", sr_start, 1);
        wp_n = 0; tick();
        compare("R6 inflight blocks", sr_wr_ok, 0);
        run_busy(4);
        compare("R8 late wp fall no effect", stat_byte, 8'h0C);
        compare("R5 latch cleared no array", q_ok, 2'b00);

        strobe_set();
        qa0 = 15'h0000; qa1 = 15'h3FFF; tick();
        compare("R4 all protected", q_ok, 2'b00);
        compare("R6 wp ignored when lock 0", sr_wr_ok, 1);

        sr_write(8'h08);
        run_busy(3);
        strobe_set();
        qa0 = 15'h4000; qa1 = 15'h3FFF; tick();
        compare("R4 half boundary", q_ok, 2'b10);

        cmd_wel_set = 1; cmd_wel_clr = 1; tick(); cmd_wel_set = 0; cmd_wel_clr = 0;
        compare("R3 clear wins", stat_byte, 8'h08);

        busy = 1; tick();
        strobe_set(); tick();
        busy = 0; tick();
        compare("R10 set ignored while busy", stat_byte, 8'h08);

        strobe_set();
        run_busy(2);
        compare("R3 busy end clears latch", stat_byte, 8'h08);

        strobe_set();
        rst = 1; tick(2); rst = 0; tick();
        compare("R9 bits survive reset", stat_byte, 8'h08);

        tick(4);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule